// File: doc/BRIEF.md
# Eight-Digit Display Memory Write Controller

This block is the bus-facing write side of an eight-digit LED display memory. A host drives an 8-bit data byte, a mode select and a write strobe. The strobe is sampled on the block clock, and each low-to-high transition counts as one write. With mode high the byte becomes the control word. With mode low the byte is display data, and the control word decides where it goes.

The control word chooses among three ways of entering data:
- An update that only changes settings.
- A burst that blanks the display and then takes eight data bytes for digits 1 to 8 in order.
- A single-digit mode that writes the digit whose address the control word carries.

Each digit has two 4-bit character stores, called banks A and B, which are used when the digit is decoded. A decoded digit also has a decimal-point bit that both banks share. Each digit keeps a flag recording whether it was last written as a decoded character or as a raw 8-bit segment pattern. A read port lets the display scanner fetch the presentation byte of any digit. The block also exports the shutdown, blank, character-set, raw-format and bank signals that the scanner needs.

Top module: `disp_write_ctrl`

## Requirements
- R1: One write happens for each rising edge of `wrStrobe` seen on a clock edge. Holding the strobe high for several cycles performs a single write.
- R2: A write with `modeSel` high loads the control word, and the status outputs follow it from the next cycle. The fields are:
  - bit 4 low: `dispShutdown` = 1
  - bit 5 high: raw format, `rawFmt` = 1
  - bit 6 high: hexadecimal, `hexSel` = 1; low selects the alternate set
  - bit 3 high: bank A, `bankSel` = 1; low selects bank B
- R3: A control word with bit 7 low changes no stored digit data. Its bits 2..0 become the single-digit target address, where 0 is digit 1 (`rdAddr` 0) and 7 is digit 8, with bit 2 as the MSB.
- R4: In single-digit mode a data write stores into the addressed digit only. Later data writes keep going to the same digit until a new control word arrives.
- R5: A control word with bit 7 high raises `dispBlank` in the next cycle. The next eight data writes fill digits 1 to 8 in order, and `dispBlank` falls after the eighth write.
- R6: After a burst completes, data writes change nothing until a new control word is written. A new control word with bit 7 low makes data writes take effect again.
- R7: A data write in decoded format stores bits 3..0 in the bank named by control bit 3 and stores bit 7 as the decimal point. The other bank is left unchanged. A decoded digit reads back as `{dp, 3'b000, nibble of the currently selected bank}`.
- R8: A data write in raw format stores all 8 bits, and the digit reads back as that byte with `rdRaw` = 1. Each digit's raw/decoded flag is taken from the control word in force when that digit is written.
- R9: Data and control writes are accepted while `dispShutdown` is 1.
- R10: After reset:
  - every digit reads 0x00 with `rdRaw` = 0
  - `dispShutdown`, `dispBlank` and `rawFmt` are 0
  - `hexSel` and `bankSel` are 1
  - the single-digit address is 0
- R11: Switching banks with a control word changes which nibble a decoded digit shows, without altering either bank's stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 8 | Control word or display data byte |
| modeSel | input | 1 | 1 = control write, 0 = data write |
| wrStrobe | input | 1 | Write strobe; a rising edge performs a write |
| rdAddr | input | 3 | Digit index for the scanner read port |
| rdByte | output | 8 | Presentation byte of the digit at `rdAddr` |
| rdRaw | output | 1 | Digit at `rdAddr` holds a raw segment pattern |
| dispShutdown | output | 1 | Shutdown requested |
| dispBlank | output | 1 | Display blanked while a burst is in progress |
| hexSel | output | 1 | 1 = hexadecimal set, 0 = alternate set |
| rawFmt | output | 1 | Control word selects raw format |
| bankSel | output | 1 | 1 = bank A, 0 = bank B |

## Verification
The bench holds the strobe high for several cycles in the middle of a burst. A level-sensitive design would advance the burst pointer more than once and spread one byte over several digits.

It writes to a finished burst to catch a pointer that wraps to digit 1 instead of freezing. It also checks that a new control word re-arms data writes.

It loads bank B, flips to bank A and back, and mixes raw and decoded digits. A design that shared one nibble store, or applied the global format to every digit instead of each digit's own flag, would read back the wrong bytes. A single-digit target that drifted after its first write would corrupt the neighbouring digit.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int DATA_W     = 8;
  localparam int NIB_W      = 4;
  localparam int NUM_DIGITS = 8;
  localparam int ADDR_W     = $clog2(NUM_DIGITS);
  localparam int UPPER_W    = DATA_W - NIB_W - 1;

  // control word field positions; the host encodes these
  localparam int CB_BANK   = 3;
  localparam int CB_SHDN_N = 4;
  localparam int CB_RAW    = 5;
  localparam int CB_HEX    = 6;
  localparam int CB_BURST  = 7;
  localparam int DP_BIT    = DATA_W - 1;

  localparam logic [DATA_W-1:0] RESET_CTRL =
    DATA_W'((1 << CB_HEX) | (1 << CB_SHDN_N) | (1 << CB_BANK));

  typedef enum logic [1:0] {
    ST_SINGLE = 2'd0,
    ST_BURST  = 2'd1,
    ST_DONE   = 2'd2
  } wrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic              rawWr;
    logic              bankA;
    logic [DATA_W-1:0] wrData;
  } storeCmd_t;
endpackage

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
  import dwc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              modeSel,
  input  logic              wrStrobe,
  output storeCmd_t         cmd,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              burstActive
);
  localparam logic [ADDR_W-1:0] LAST_DIGIT = ADDR_W'(NUM_DIGITS - 1);

  logic              wrPrev;
  logic              wrEdge;
  logic              ctrlWrite;
  logic              dataWrite;
  logic [DATA_W-1:0] ctrlReg;
  wrState_e          state;
  logic [ADDR_W-1:0] burstCnt;

  // synchronous edge detect on the strobe
  always_ff @(posedge clk) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrStrobe;
  end

  assign wrEdge    = wrStrobe && !wrPrev;
  assign ctrlWrite = wrEdge && modeSel;
  assign dataWrite = wrEdge && !modeSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= RESET_CTRL;
      state    <= ST_SINGLE;
      burstCnt <= '0;
    end else if (ctrlWrite) begin
      ctrlReg  <= dataIn;
      state    <= dataIn[CB_BURST] ? ST_BURST : ST_SINGLE;
      burstCnt <= '0;
    end else if (dataWrite && state == ST_BURST) begin
      burstCnt <= burstCnt + 1'b1;
      if (burstCnt == LAST_DIGIT) state <= ST_DONE;
    end
  end

  always_comb begin
    cmd.wrEn   = dataWrite && (state != ST_DONE);
    cmd.wrAddr = (state == ST_BURST) ? burstCnt : ctrlReg[ADDR_W-1:0];
    cmd.rawWr  = ctrlReg[CB_RAW];
    cmd.bankA  = ctrlReg[CB_BANK];
    cmd.wrData = dataIn;
  end

  assign ctrlWord    = ctrlReg;
  assign burstActive = (state == ST_BURST);

  // R1: a strobe already high on the previous cycle produces no write
  assert_single_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && $past(wrStrobe)) |-> !cmd.wrEn);

  // R2: a control write is captured whole
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (ctrlWord == $past(dataIn)));

  // R5: a burst-announcing control word blanks the display next cycle
  assert_burst_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && dataIn[CB_BURST]) |=> burstActive);

  // R6: once the burst is finished, data writes are not passed on
  assert_done_ignores_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !ctrlWrite) |=> (state == ST_DONE));
endmodule

// File: rtl/dwc_store.sv
module dwc_store
  import dwc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  storeCmd_t         cmd,
  input  logic              showBankA,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdByte,
  output logic              rdRaw
);
  logic [NUM_DIGITS-1:0][NIB_W-1:0]   bankAMem;
  logic [NUM_DIGITS-1:0][NIB_W-1:0]   bankBMem;
  logic [NUM_DIGITS-1:0][UPPER_W-1:0] upperMem;
  logic [NUM_DIGITS-1:0]              dpMem;
  logic [NUM_DIGITS-1:0]              rawFlag;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    logic hit;
    assign hit = cmd.wrEn && (cmd.wrAddr == ADDR_W'(d));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankAMem[d] <= '0;
        bankBMem[d] <= '0;
        upperMem[d] <= '0;
        dpMem[d]    <= 1'b0;
        rawFlag[d]  <= 1'b0;
      end else if (hit) begin
        dpMem[d]   <= cmd.wrData[DP_BIT];
        rawFlag[d] <= cmd.rawWr;
        if (cmd.rawWr) begin
          bankAMem[d] <= cmd.wrData[NIB_W-1:0];
          upperMem[d] <= cmd.wrData[DP_BIT-1:NIB_W];
        end else if (cmd.bankA) begin
          bankAMem[d] <= cmd.wrData[NIB_W-1:0];
        end else begin
          bankBMem[d] <= cmd.wrData[NIB_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdRaw = rawFlag[rdAddr];
    if (rawFlag[rdAddr])
      rdByte = {dpMem[rdAddr], upperMem[rdAddr], bankAMem[rdAddr]};
    else
      rdByte = {dpMem[rdAddr], {UPPER_W{1'b0}},
                showBankA ? bankAMem[rdAddr] : bankBMem[rdAddr]};
  end

  // R8: the written digit takes its format flag from the control word
  assert_raw_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |=> (rawFlag[$past(cmd.wrAddr)] == $past(cmd.rawWr)));

  // R7: a decoded write to bank A leaves bank B untouched
  assert_other_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && !cmd.rawWr && cmd.bankA) |=> $stable(bankBMem));

  // R3: without a write strobe from control, no stored digit moves
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wrEn |=> ($stable(bankAMem) && $stable(bankBMem) &&
                   $stable(dpMem) && $stable(rawFlag) && $stable(upperMem)));
endmodule

// File: rtl/disp_write_ctrl.sv
module disp_write_ctrl
  import dwc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              modeSel,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdByte,
  output logic              rdRaw,
  output logic              dispShutdown,
  output logic              dispBlank,
  output logic              hexSel,
  output logic              rawFmt,
  output logic              bankSel
);
  storeCmd_t         storeCmd;
  logic [DATA_W-1:0] ctrlWord;
  logic              burstActive;

  dwc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (dataIn),
    .modeSel    (modeSel),
    .wrStrobe   (wrStrobe),
    .cmd        (storeCmd),
    .ctrlWord   (ctrlWord),
    .burstActive(burstActive)
  );

  dwc_store u_store (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (storeCmd),
    .showBankA(ctrlWord[CB_BANK]),
    .rdAddr   (rdAddr),
    .rdByte   (rdByte),
    .rdRaw    (rdRaw)
  );

  assign dispShutdown = !ctrlWord[CB_SHDN_N];
  assign dispBlank    = burstActive;
  assign hexSel       = ctrlWord[CB_HEX];
  assign rawFmt       = ctrlWord[CB_RAW];
  assign bankSel      = ctrlWord[CB_BANK];

  // R9: shutdown does not stop data writes reaching the store
  assert_shutdown_writes_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dispShutdown && wrStrobe && !$past(wrStrobe) && !modeSel && !dispBlank &&
     $past(rstN)) |-> storeCmd.wrEn);
endmodule

// File: tb/disp_write_ctrl_tb.sv
`timescale 1ns/1ps
module disp_write_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] dataIn = '0;
  logic       modeSel = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdByte;
  logic       rdRaw, dispShutdown, dispBlank, hexSel, rawFmt, bankSel;

  always #2.5 clk = ~clk;

  disp_write_ctrl u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .modeSel(modeSel),
    .wrStrobe(wrStrobe), .rdAddr(rdAddr), .rdByte(rdByte), .rdRaw(rdRaw),
    .dispShutdown(dispShutdown), .dispBlank(dispBlank), .hexSel(hexSel),
    .rawFmt(rawFmt), .bankSel(bankSel)
  );

  typedef struct {
    int         addr;
    logic [7:0] b;
    logic       r;
    logic [4:0] st;
    string      tag;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // behavioural model built from the requirements
  logic [7:0] mCtrl;
  logic [3:0] mA [8];
  logic [3:0] mB [8];
  logic [2:0] mUp [8];
  logic       mDp [8];
  logic       mFlag [8];
  int         mState; // 0 single, 1 burst, 2 done
  int         mCnt;

  task automatic modelReset();
    mCtrl = 8'h58; mState = 0; mCnt = 0;
    for (int i = 0; i < 8; i++) begin
      mA[i] = '0; mB[i] = '0; mUp[i] = '0; mDp[i] = 1'b0; mFlag[i] = 1'b0;
    end
  endtask

  task automatic doWrite(input logic m, input logic [7:0] d, input int hold = 1);
    @(negedge clk);
    modeSel = m; dataIn = d; wrStrobe = 1'b1;
    repeat (hold) @(negedge clk);
    wrStrobe = 1'b0;
    @(negedge clk);
    if (m) begin
      mCtrl = d;
      mState = d[7] ? 1 : 0;
      mCnt = 0;
    end else if (mState != 2) begin
      int a;
      a = (mState == 1) ? mCnt : int'(mCtrl[2:0]);
      mDp[a] = d[7];
      mFlag[a] = mCtrl[5];
      if (mCtrl[5]) begin
        mA[a] = d[3:0]; mUp[a] = d[6:4];
      end else if (mCtrl[3]) mA[a] = d[3:0];
      else mB[a] = d[3:0];
      if (mState == 1) begin
        mCnt++;
        if (mCnt == 8) mState = 2;
      end
    end
  endtask

  task automatic expectDigit(input int a, input string tag);
    item_t it;
    it.addr = a;
    it.r = mFlag[a];
    it.b = mFlag[a] ? {mDp[a], mUp[a], mA[a]}
                    : {mDp[a], 3'b000, (mCtrl[3] ? mA[a] : mB[a])};
    it.st = {(mState == 1), !mCtrl[4], mCtrl[6], mCtrl[5], mCtrl[3]};
    it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [4:0] st;
      it = q.pop_front();
      rdAddr = 3'(it.addr);
      #1;
      st = {dispBlank, dispShutdown, hexSel, rawFmt, bankSel};
      nChecks++;
      if (rdByte !== it.b || rdRaw !== it.r || st !== it.st) begin
        nFails++;
        $display("FAIL %s digit %0d: byte %h raw %b status %b, expected byte %h raw %b status %b",
                 it.tag, it.addr, rdByte, rdRaw, st, it.b, it.r, it.st);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    expectDigit(0, "R10 reset digit1");
    expectDigit(7, "R10 reset digit8");

    // R3/R4: single-digit target 2, bank A, hex
    doWrite(1, 8'h5A);
    doWrite(0, 8'h8C);
    expectDigit(2, "R4 single write");
    expectDigit(1, "R4 neighbour untouched");
    doWrite(0, 8'h05);
    expectDigit(2, "R4 same address again");
    doWrite(1, 8'h5B);
    expectDigit(2, "R3 control-only keeps data");
    expectDigit(3, "R3 new target not written");

    // R7/R11: bank B then switch
    doWrite(1, 8'h53);
    doWrite(0, 8'h07);
    expectDigit(3, "R7 bank B write");
    doWrite(1, 8'h5B);
    expectDigit(3, "R11 bank A view");
    doWrite(1, 8'h53);
    expectDigit(3, "R11 bank B view restored");

    // R8: raw write to digit 5
    doWrite(1, 8'h75);
    doWrite(0, 8'hA6);
    expectDigit(5, "R8 raw byte");
    expectDigit(3, "R8 decoded digit keeps own flag");

    // R9: shutdown still accepts writes
    doWrite(1, 8'h4E);
    doWrite(0, 8'h03);
    expectDigit(6, "R9 write in shutdown");

    // R2: alternate set selected
    doWrite(1, 8'h1E);
    expectDigit(6, "R2 status alternate set");

    // R5/R1: burst with held strobe on the first write
    doWrite(1, 8'hD8);
    expectDigit(0, "R5 burst blanks");
    doWrite(0, 8'h81, 4);
    expectDigit(0, "R1 held strobe first digit");
    expectDigit(1, "R1 held strobe single advance");
    for (int i = 1; i < 8; i++) doWrite(0, 8'(i * 3));
    for (int i = 0; i < 8; i++) expectDigit(i, "R5 burst fill");

    // R6: writes after burst ignored, then re-armed
    doWrite(0, 8'h0F);
    expectDigit(0, "R6 ignored after burst");
    expectDigit(7, "R6 ignored after burst last");
    doWrite(1, 8'h58);
    doWrite(0, 8'h09);
    expectDigit(0, "R6 re-armed by control word");

    // R5/R8: raw burst
    doWrite(1, 8'hF8);
    for (int i = 0; i < 8; i++) doWrite(0, 8'(8'h11 * i + 8'h20));
    for (int i = 0; i < 8; i++) expectDigit(i, "R8 raw burst");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule